// File: doc/BRIEF.md
# Serial NOR Cell Network Evaluator

This block stands in for a person working a paper NOR computer, one cell per clock. A fixed cell table lists each helper cell and each output cell together with the cells it reads. Every cell reads one to three other cells. A cell's value is 1 only when all of its inputs are 0. The netlist in the table moves a one-pixel ball back and forth across a four-pixel line.

Software or a neighbouring block first loads a 3-bit starting state while the evaluator is idle. It then pulses start. The block walks the table in a fixed order and writes each result into a cell register. After the last cell it copies the next-state cells into the current-state cells and publishes the four screen cells. It then raises a one-cycle frame-done pulse. Each further start pulse computes one more frame of the animation.

Top module: `nor_cell_eval`

## Requirements
- R1: While reset is held, and after it is released until the first completed frame, `busy` and `frameDone` are 0 and `screen` is 4'b0000. The current-state cells reset to 000.
- R2: When `loadStrobe` is sampled high while the block is idle, `initState[2]`, `initState[1]` and `initState[0]` become current-state cells i2, i1 and i0.
- R3: Every cell takes the NOR of its inputs, using this netlist:
  - helpers: p0=NOR(i0), p1=NOR(i1), p2=NOR(i2), p3=NOR(p2,p0), p4=NOR(p2,i1,p0), p5=NOR(i2,p1,p0)
  - screen cells: o0=NOR(i1,i0), o1=NOR(i1,p0), o2=NOR(p1,p0), o3=NOR(p1,i0)
  - next-state cells: o4=NOR(p4,p5), o5=NOR(o0,p3), o6=NOR(p1)
- R4: The cells are evaluated one per clock in the order p0..p5, then o0..o3, then o4..o6, followed by one transfer cycle. A start pulse sampled while idle sets `busy` on that edge. `frameDone` then rises on the 14th following edge, and `busy` stays 1 throughout.
- R5: `frameDone` is high for exactly one cycle, and `busy` is 0 while it is high.
- R6: `screen` = {o3,o2,o1,o0} (bit 3 down to bit 0) of the frame just evaluated. It changes only on the edge that raises `frameDone`, and in a completed frame exactly one of its bits is set.
- R7: The transfer cycle copies o6, o5 and o4 into i2, i1 and i0, so successive frames follow the netlist. From state 000 the screens run 0001, 0010, 0100, 1000, 0100, 0010 and then repeat.
- R8: A start pulse sampled while `busy` is 1 is ignored. The frame in progress is neither restarted nor followed by an extra frame.
- R9: A load strobe sampled while `busy` is 1 is ignored. Neither the current frame nor the state it transfers is changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin evaluating one frame |
| initState | input | 3 | State value written by a load |
| loadStrobe | input | 1 | Write initState into the current-state cells |
| busy | output | 1 | A frame is being evaluated |
| frameDone | output | 1 | One-cycle pulse when a frame completes |
| screen | output | 4 | Screen cells {o3,o2,o1,o0} of the last frame |

## Verification
The assertions watch the frame framing on every cycle. They check that the done pulse lasts one cycle and that busy is low while it is high. They check that busy falls only together with that pulse, and that a frame spans exactly fourteen busy cycles. They also check that the screen holds between pulses and carries a single lit pixel when one arrives. Whether the NOR results and the state transfer are correct can only be seen in the bench's scenarios. The bench loads all eight starting states, follows the bouncing sequence over many frames, and injects a start or a load in the middle of a frame.

// File: rtl/nce_pkg.sv
package nce_pkg;
  localparam int STATE_W   = 3;
  localparam int HELPER_N  = 6;
  localparam int SCREEN_W  = 4;
  localparam int OUT_N     = SCREEN_W + STATE_W;
  localparam int CELL_N    = STATE_W + HELPER_N + OUT_N;
  localparam int STEP_N    = HELPER_N + OUT_N;
  localparam int MAX_FANIN = 3;
  localparam int IDX_W     = $clog2(CELL_N);
  localparam int STEP_W    = $clog2(STEP_N + 1);
  localparam int FAN_W     = $clog2(MAX_FANIN + 1);
  localparam int SCREEN_BASE = STATE_W + HELPER_N;
  localparam int NEXT_BASE   = SCREEN_BASE + SCREEN_W;

  typedef logic [IDX_W-1:0] cellIdxT;

  typedef struct packed {
    cellIdxT                      dest;
    logic [FAN_W-1:0]             fanIn;
    logic [MAX_FANIN-1:0][IDX_W-1:0] src;
  } cellEntryT;

  typedef struct packed {
    logic              evalEn;
    logic [STEP_W-1:0] step;
    logic              commit;
    logic              load;
  } ctrlT;

  function automatic cellIdxT iCell(input int n);
    return cellIdxT'(n);
  endfunction
  function automatic cellIdxT pCell(input int n);
    return cellIdxT'(STATE_W + n);
  endfunction
  function automatic cellIdxT oCell(input int n);
    return cellIdxT'(SCREEN_BASE + n);
  endfunction

  function automatic cellEntryT mkEntry(input cellIdxT d, input int n,
                                        input cellIdxT a, input cellIdxT b, input cellIdxT c);
    cellEntryT e;
    e.dest   = d;
    e.fanIn  = FAN_W'(n);
    e.src[0] = a;
    e.src[1] = b;
    e.src[2] = c;
    return e;
  endfunction

  // Evaluation order: helpers, screen cells, then next-state cells (o5 reads o0).
  function automatic cellEntryT cellAt(input logic [STEP_W-1:0] step);
    case (step)
      STEP_W'(0):  return mkEntry(pCell(0), 1, iCell(0), iCell(0), iCell(0));
      STEP_W'(1):  return mkEntry(pCell(1), 1, iCell(1), iCell(0), iCell(0));
      STEP_W'(2):  return mkEntry(pCell(2), 1, iCell(2), iCell(0), iCell(0));
      STEP_W'(3):  return mkEntry(pCell(3), 2, pCell(2), pCell(0), iCell(0));
      STEP_W'(4):  return mkEntry(pCell(4), 3, pCell(2), iCell(1), pCell(0));
      STEP_W'(5):  return mkEntry(pCell(5), 3, iCell(2), pCell(1), pCell(0));
      STEP_W'(6):  return mkEntry(oCell(0), 2, iCell(1), iCell(0), iCell(0));
      STEP_W'(7):  return mkEntry(oCell(1), 2, iCell(1), pCell(0), iCell(0));
      STEP_W'(8):  return mkEntry(oCell(2), 2, pCell(1), pCell(0), iCell(0));
      STEP_W'(9):  return mkEntry(oCell(3), 2, pCell(1), iCell(0), iCell(0));
      STEP_W'(10): return mkEntry(oCell(4), 2, pCell(4), pCell(5), iCell(0));
      STEP_W'(11): return mkEntry(oCell(5), 2, oCell(0), pCell(3), iCell(0));
      STEP_W'(12): return mkEntry(oCell(6), 1, pCell(1), iCell(0), iCell(0));
      default:     return mkEntry(pCell(0), 1, iCell(0), iCell(0), iCell(0));
    endcase
  endfunction
endpackage

// File: rtl/nce_control.sv
module nce_control
  import nce_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic startPulse,
  input  logic loadStrobe,
  output ctrlT ctrl,
  output logic busy,
  output logic frameDone
);
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_COMMIT} phaseT;

  phaseT             phase;
  logic [STEP_W-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= S_IDLE;
      stepCnt   <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= (phase == S_COMMIT);
      case (phase)
        S_IDLE: begin
          if (startPulse) begin
            phase   <= S_EVAL;
            stepCnt <= '0;
          end
        end
        S_EVAL: begin
          if (stepCnt == STEP_W'(STEP_N - 1)) phase <= S_COMMIT;
          else stepCnt <= stepCnt + 1'b1;
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.evalEn = (phase == S_EVAL);
    ctrl.step   = stepCnt;
    ctrl.commit = (phase == S_COMMIT);
    ctrl.load   = (phase == S_IDLE) && loadStrobe;
    busy        = (phase != S_IDLE);
  end
endmodule

// File: rtl/nce_datapath.sv
module nce_datapath
  import nce_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlT                ctrl,
  input  logic [STATE_W-1:0]  initState,
  output logic [SCREEN_W-1:0] screen
);
  logic [CELL_N-1:0] cellVal;
  cellEntryT         entry;
  logic              anyHigh;
  logic              norVal;

  always_comb begin
    entry   = cellAt(ctrl.step);
    anyHigh = 1'b0;
    for (int k = 0; k < MAX_FANIN; k++) begin
      if (k < int'(entry.fanIn)) anyHigh = anyHigh | cellVal[entry.src[k]];
    end
    norVal = ~anyHigh;
  end

  for (genvar c = 0; c < CELL_N; c++) begin : gCell
    logic q;
    if (c < STATE_W) begin : gState
      always_ff @(posedge clk) begin
        if (!rstN)            q <= 1'b0;
        else if (ctrl.load)   q <= initState[c];
        else if (ctrl.commit) q <= cellVal[NEXT_BASE + c];
      end
    end else begin : gWork
      always_ff @(posedge clk) begin
        if (!rstN) q <= 1'b0;
        else if (ctrl.evalEn && entry.dest == cellIdxT'(c)) q <= norVal;
      end
    end
    assign cellVal[c] = q;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            screen <= '0;
    else if (ctrl.commit) screen <= cellVal[SCREEN_BASE +: SCREEN_W];
  end
endmodule

// File: rtl/nor_cell_eval.sv
module nor_cell_eval
  import nce_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                startPulse,
  input  logic [STATE_W-1:0]  initState,
  input  logic                loadStrobe,
  output logic                busy,
  output logic                frameDone,
  output logic [SCREEN_W-1:0] screen
);
  ctrlT ctrl;

  nce_control uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .loadStrobe (loadStrobe),
    .ctrl       (ctrl),
    .busy       (busy),
    .frameDone  (frameDone)
  );

  nce_datapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .initState (initState),
    .screen    (screen)
  );
endmodule

// File: rtl/nce_checker.sv
module nce_checker
  import nce_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                startPulse,
  input logic                busy,
  input logic                frameDone,
  input logic [SCREEN_W-1:0] screen
);
  logic [STEP_W:0] spanCnt;

  always_ff @(posedge clk) begin
    if (!rstN)     spanCnt <= '0;
    else if (!busy) spanCnt <= '0;
    else           spanCnt <= spanCnt + 1'b1;
  end

  AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rstN) frameDone |=> !frameDone); // R5
  AST_DONE_IDLE:    assert property (@(posedge clk) disable iff (!rstN) frameDone |-> !busy); // R5
  AST_BUSY_TO_DONE: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> frameDone); // R4
  AST_START_BUSY:   assert property (@(posedge clk) disable iff (!rstN) (startPulse && !busy) |=> busy); // R4
  AST_FRAME_SPAN:   assert property (@(posedge clk) disable iff (!rstN) frameDone |-> (int'(spanCnt) == STEP_N + 1)); // R8
  AST_SCREEN_HOLD:  assert property (@(posedge clk) disable iff (!rstN) !frameDone |-> $stable(screen)); // R6
  AST_SCREEN_ONE:   assert property (@(posedge clk) disable iff (!rstN) frameDone |-> ($countones(screen) == 1)); // R6
endmodule

bind nor_cell_eval nce_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .busy       (busy),
  .frameDone  (frameDone),
  .screen     (screen)
);

// File: tb/nor_cell_eval_test.sv
module nor_cell_eval_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic [2:0] initState = 3'b000;
  logic       loadStrobe = 1'b0;
  logic       busy;
  logic       frameDone;
  logic [3:0] screen;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  nor_cell_eval uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .initState(initState),
    .loadStrobe(loadStrobe), .busy(busy), .frameDone(frameDone), .screen(screen)
  );

  // Reference netlist straight from R3; returns {o6..o0}
  function automatic logic [6:0] refCells(input logic [2:0] s);
    logic i0, i1, i2, p0, p1, p2, p3, p4, p5, o0, o1, o2, o3, o4, o5, o6;
    i0 = s[0]; i1 = s[1]; i2 = s[2];
    p0 = ~i0; p1 = ~i1; p2 = ~i2;
    p3 = ~(p2 | p0); p4 = ~(p2 | i1 | p0); p5 = ~(i2 | p1 | p0);
    o0 = ~(i1 | i0); o1 = ~(i1 | p0); o2 = ~(p1 | p0); o3 = ~(p1 | i0);
    o4 = ~(p4 | p5); o5 = ~(o0 | p3); o6 = ~p1;
    return {o6, o5, o4, o3, o2, o1, o0};
  endfunction
  function automatic logic [3:0] refScreen(input logic [2:0] s);
    logic [6:0] c = refCells(s);
    return c[3:0];
  endfunction
  function automatic logic [2:0] refNext(input logic [2:0] s);
    logic [6:0] c = refCells(s);
    return c[6:4];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doLoad(input logic [2:0] v);
    @(negedge clk);
    initState = v;
    loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
  endtask

  // injKind: 0 none, 1 start pulse, 2 load strobe, driven at cycle injAt of the frame
  task automatic runFrame(input int injAt, input int injKind, input logic [2:0] injVal);
    int cyc = 0;
    bit busyDrop = 1'b0;
    @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check(busy === 1'b1, "R4 busy after start", int'(busy), 1);
    while (!frameDone && cyc < 40) begin
      if (cyc == injAt && injKind == 1) startPulse = 1'b1;
      if (cyc == injAt && injKind == 2) begin
        initState = injVal;
        loadStrobe = 1'b1;
      end
      @(negedge clk);
      startPulse = 1'b0;
      loadStrobe = 1'b0;
      cyc++;
      if (!frameDone && !busy) busyDrop = 1'b1;
    end
    check(cyc == 14, "R4 frame latency", cyc, 14);
    check(!busyDrop, "R4 busy held during frame", int'(busyDrop), 0);
    check(busy === 1'b0, "R5 busy low at done", int'(busy), 0);
    @(negedge clk);
    check(frameDone === 1'b0, "R5 done lasts one cycle", int'(frameDone), 0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && frameDone === 1'b0 && screen === 4'b0000,
          "R1 outputs in reset", int'({busy, frameDone, screen}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && frameDone === 1'b0 && screen === 4'b0000,
          "R1 outputs after reset", int'({busy, frameDone, screen}), 0);
    runFrame(-1, 0, 3'b000);
    check(screen === refScreen(3'b000), "R1 reset state is 000", int'(screen), int'(refScreen(3'b000)));
  endtask

  task automatic testEveryState();
    for (int s = 0; s < 8; s++) begin
      doLoad(3'(s));
      runFrame(-1, 0, 3'b000);
      check(screen === refScreen(3'(s)), "R2 R3 screen of loaded state", int'(screen), int'(refScreen(3'(s))));
      runFrame(-1, 0, 3'b000);
      check(screen === refScreen(refNext(3'(s))), "R3 R7 screen of next state",
            int'(screen), int'(refScreen(refNext(3'(s)))));
    end
  endtask

  task automatic testBounce();
    logic [3:0] expSeq [6] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0100, 4'b0010};
    logic [2:0] s = 3'b000;
    doLoad(3'b000);
    for (int f = 0; f < 12; f++) begin
      runFrame(-1, 0, 3'b000);
      check(screen === expSeq[f % 6], "R7 bounce sequence", int'(screen), int'(expSeq[f % 6]));
      check(screen === refScreen(s), "R7 model sequence", int'(screen), int'(refScreen(s)));
      s = refNext(s);
    end
  endtask

  task automatic testScreenHold();
    logic [3:0] held;
    doLoad(3'b110);
    runFrame(-1, 0, 3'b000);
    held = screen;
    check(held === 4'b1000, "R6 screen bit3 is o3", int'(held), 8);
    doLoad(3'b000);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(screen === held && frameDone === 1'b0, "R6 screen holds between frames", int'(screen), int'(held));
    end
  endtask

  task automatic testStartWhileBusy();
    doLoad(3'b000);
    runFrame(5, 1, 3'b000);
    check(screen === 4'b0001, "R8 frame result intact", int'(screen), 1);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(frameDone === 1'b0 && busy === 1'b0, "R8 no extra frame", int'({busy, frameDone}), 0);
    end
  endtask

  task automatic testLoadWhileBusy();
    doLoad(3'b000);
    runFrame(7, 2, 3'b111);
    check(screen === 4'b0001, "R9 frame unaffected by load", int'(screen), 1);
    runFrame(-1, 0, 3'b000);
    check(screen === refScreen(refNext(3'b000)), "R9 transferred state unaffected",
          int'(screen), int'(refScreen(refNext(3'b000))));
  endtask

  initial begin
    #200000;
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    testReset();
    testEveryState();
    testBounce();
    testScreenHold();
    testStartWhileBusy();
    testLoadWhileBusy();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule